// File: doc/BRIEF.md
# DMA Versus Processor Shared-Path Arbiter

This block decides, on every clock, who drives the shared memory path: one of several DMA channels, or the processor (and, through it, any interrupt service). All channels share one DMA priority level. That level is compared against the processor's live priority level, and a DMA channel may take a fresh grant only when its level is at least the processor's. While a channel holds the path, the processor runs nothing, interrupt handlers included. When a qualifying transfer and an interrupt are both waiting, the transfer goes first.

Software arms a channel by pulsing that channel's bit on the launch input. An armed channel competes for the path whenever it raises its request. The lowest-numbered armed requester wins, and it keeps the path until it drops its request. Each end-of-descriptor pulse comes with an interrupt-enable flag and a last-descriptor flag. An enabled end sets a sticky DMA interrupt request, which clears when the processor acknowledges it. A last-descriptor end disarms the channel.

All ports are plain control and status pins. No data flows through the block, so it has no valid/ready stream. Grants are registered and change one clock after the inputs that cause them.

Top module: `dma_cpu_arbiter`

## Requirements
- R1: After reset, cpu_grant is 1, dma_grant is 0, dma_grant_ch is all zero, dma_irq is 0 and ch_armed is all zero.
- R2: A new DMA grant is issued only if dma_level >= cpu_level, both taken as unsigned 0..3. A raised cpu_level blocks new grants from the next clock onward.
- R3: One dma_level governs every channel. At dma_level 3 a grant can happen at any processor level. At dma_level 0 it can happen only when cpu_level is 0.
- R4: cpu_grant is always the inverse of dma_grant. irq_grant equals cpu_grant AND irq_pending, so an eligible DMA transfer is served ahead of a pending interrupt.
- R5: ch_launch[i] sets ch_armed[i] on the next clock. A desc_end[i] together with desc_last[i] clears it. If launch and the clear arrive in the same clock, launch wins. An unarmed channel's request is ignored.
- R6: Among armed, requesting channels, the lowest index wins. dma_grant_ch is one-hot with bit i meaning channel i, and dma_grant = |dma_grant_ch.
- R7: A granted channel keeps the grant while its request stays high, even if cpu_level rises or a lower channel starts requesting. When it drops its request, the path can pass to another eligible channel on that same clock.
- R8: Grants are registered: a request seen at one clock edge shows on dma_grant_ch right after that edge, and an armed bit set at an edge first takes part in the following decision.
- R9: desc_end[i] with desc_irq_en[i] sets dma_irq on the next clock. A desc_end without its enable leaves dma_irq unchanged.
- R10: irq_ack clears dma_irq on the next clock. If an enabled desc_end arrives in the same clock, dma_irq stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_level | input | 2 | Current processor priority level |
| dma_level | input | 2 | Global DMA priority level |
| ch_req | input | NUM_CH | Per-channel transfer request |
| ch_launch | input | NUM_CH | Per-channel start strobe |
| desc_end | input | NUM_CH | Per-channel end-of-descriptor pulse |
| desc_last | input | NUM_CH | Qualifies desc_end as the final descriptor |
| desc_irq_en | input | NUM_CH | Qualifies desc_end to raise the interrupt |
| irq_pending | input | 1 | An interrupt is waiting for the processor |
| irq_ack | input | 1 | Processor acknowledges the DMA interrupt |
| dma_grant | output | 1 | A DMA channel owns the path |
| dma_grant_ch | output | NUM_CH | One-hot owning channel |
| cpu_grant | output | 1 | Processor owns the path |
| irq_grant | output | 1 | Interrupt service may proceed |
| dma_irq | output | 1 | Sticky DMA interrupt request |
| ch_armed | output | NUM_CH | Channels launched and not yet finished |

## Verification
The bench builds the block with NUM_CH = 4. With four channels, armed and unarmed requesters can be mixed in one request word, so the lowest-index choice and the masking of unarmed channels are both exercised. There is room for a low channel to compete against a held higher grant and for a direct handoff between two channels. Because the level width is fixed at two bits, all four DMA levels are reachable, including both extreme levels and the equal-level boundary.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LEVEL_W = 2;
  typedef logic [LEVEL_W-1:0] level_t;
endpackage

// File: rtl/arb_elig.sv
module arb_elig
  import arb_pkg::*;
(
  input  level_t cpu_level,
  input  level_t dma_level,
  output logic   eligible
);
  // unsigned compare: equal levels qualify
  always_comb eligible = (dma_level >= cpu_level);
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] onehot,
  output logic         found
);
  // lowest index first
  always_comb begin
    logic seen;
    seen   = 1'b0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      onehot[i] = cand[i] & ~seen;
      seen      = seen | cand[i];
    end
    found = seen;
  end
endmodule

// File: rtl/arb_chan_state.sv
module arb_chan_state #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] launch,
  input  logic [N-1:0] desc_end,
  input  logic [N-1:0] desc_last,
  output logic [N-1:0] armed
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic armed_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         armed_q <= 1'b0;
      else if (launch[i])                 armed_q <= 1'b1;
      else if (desc_end[i] && desc_last[i]) armed_q <= 1'b0;
    end
    assign armed[i] = armed_q;

    p_launch_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      launch[i] |=> armed[i]);
    p_last_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_end[i] && desc_last[i] && !launch[i]) |=> !armed[i]);
  end
endmodule

// File: rtl/arb_irq.sv
module arb_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] desc_end,
  input  logic [N-1:0] desc_irq_en,
  input  logic         irq_ack,
  output logic         dma_irq
);
  logic set_req;
  always_comb set_req = |(desc_end & desc_irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n)       dma_irq <= 1'b0;
    else if (set_req) dma_irq <= 1'b1;
    else if (irq_ack) dma_irq <= 1'b0;
  end

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(desc_end & desc_irq_en)) |=> dma_irq);
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(|(desc_end & desc_irq_en))) |=> !dma_irq);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq && !irq_ack) |=> dma_irq);
endmodule

// File: rtl/dma_cpu_arbiter.sv
module dma_cpu_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [arb_pkg::LEVEL_W-1:0] cpu_level,
  input  logic [arb_pkg::LEVEL_W-1:0] dma_level,
  input  logic [NUM_CH-1:0]           ch_req,
  input  logic [NUM_CH-1:0]           ch_launch,
  input  logic [NUM_CH-1:0]           desc_end,
  input  logic [NUM_CH-1:0]           desc_last,
  input  logic [NUM_CH-1:0]           desc_irq_en,
  input  logic                        irq_pending,
  input  logic                        irq_ack,
  output logic                        dma_grant,
  output logic [NUM_CH-1:0]           dma_grant_ch,
  output logic                        cpu_grant,
  output logic                        irq_grant,
  output logic                        dma_irq,
  output logic [NUM_CH-1:0]           ch_armed
);
  import arb_pkg::*;

  logic              eligible;
  logic [NUM_CH-1:0] pick_oh;
  logic              pick_found;
  logic [NUM_CH-1:0] owner_q, owner_d;
  logic              owner_holds;

  arb_elig u_elig (
    .cpu_level (level_t'(cpu_level)),
    .dma_level (level_t'(dma_level)),
    .eligible  (eligible)
  );

  arb_chan_state #(.N(NUM_CH)) u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (ch_launch),
    .desc_end  (desc_end),
    .desc_last (desc_last),
    .armed     (ch_armed)
  );

  arb_pick #(.N(NUM_CH)) u_pick (
    .cand   (ch_req & ch_armed),
    .onehot (pick_oh),
    .found  (pick_found)
  );

  arb_irq #(.N(NUM_CH)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_end    (desc_end),
    .desc_irq_en (desc_irq_en),
    .irq_ack     (irq_ack),
    .dma_irq     (dma_irq)
  );

  // owner keeps the path until its request falls
  always_comb begin
    owner_holds = |(owner_q & ch_req);
    if (owner_holds)                owner_d = owner_q;
    else if (eligible && pick_found) owner_d = pick_oh;
    else                            owner_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= '0;
    else        owner_q <= owner_d;
  end

  assign dma_grant_ch = owner_q;
  assign dma_grant    = |owner_q;
  assign cpu_grant    = ~dma_grant;
  assign irq_grant    = cpu_grant & irq_pending;

  p_new_grant_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_grant && (dma_grant_ch != $past(dma_grant_ch)))
      |-> $past(dma_level >= cpu_level));
  p_new_grant_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_grant && (dma_grant_ch != $past(dma_grant_ch)))
      |-> (($past(ch_armed) & dma_grant_ch) != '0));
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_grant_ch));
  p_hold_while_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_grant_ch & ch_req)) |=> (dma_grant_ch == $past(dma_grant_ch)));
  p_no_irq_under_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(owner_q & ch_req)) |=> !irq_grant);
endmodule

// File: tb/tb_dma_cpu_arbiter.sv
module tb_dma_cpu_arbiter;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] cpu_level = 0, dma_level = 0;
  logic [N-1:0] ch_req = 0, ch_launch = 0, desc_end = 0, desc_last = 0, desc_irq_en = 0;
  logic irq_pending = 0, irq_ack = 0;
  logic dma_grant, cpu_grant, irq_grant, dma_irq;
  logic [N-1:0] dma_grant_ch, ch_armed;

  always #4 clk = ~clk;

  dma_cpu_arbiter #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_level(cpu_level), .dma_level(dma_level),
    .ch_req(ch_req), .ch_launch(ch_launch), .desc_end(desc_end),
    .desc_last(desc_last), .desc_irq_en(desc_irq_en),
    .irq_pending(irq_pending), .irq_ack(irq_ack),
    .dma_grant(dma_grant), .dma_grant_ch(dma_grant_ch), .cpu_grant(cpu_grant),
    .irq_grant(irq_grant), .dma_irq(dma_irq), .ch_armed(ch_armed)
  );

  typedef struct {
    logic [N-1:0] gch;
    logic [N-1:0] armed;
    logic         irq;
    logic         ipend;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // driver: drive at falling edge, queue the expectation for the next rising edge
  task automatic step(input logic [1:0] cl, input logic [1:0] dl,
                      input logic [N-1:0] req, input logic [N-1:0] lau,
                      input logic [N-1:0] de, input logic [N-1:0] dlast,
                      input logic [N-1:0] den, input logic ip, input logic ack,
                      input logic [N-1:0] e_gch, input logic [N-1:0] e_arm,
                      input logic e_irq, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_level = cl; dma_level = dl; ch_req = req; ch_launch = lau;
    desc_end = de; desc_last = dlast; desc_irq_en = den;
    irq_pending = ip; irq_ack = ack;
    e.gch = e_gch; e.armed = e_arm; e.irq = e_irq; e.ipend = ip; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample two ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic exp_dg, exp_ig;
        e = sb.pop_front();
        exp_dg = |e.gch;
        exp_ig = !exp_dg && e.ipend;
        vectors++;
        if (dma_grant_ch !== e.gch || dma_grant !== exp_dg || cpu_grant !== !exp_dg ||
            irq_grant !== exp_ig || ch_armed !== e.armed || dma_irq !== e.irq) begin
          miscompares++;
          $display("FAIL %s: got gch=%b dg=%b cg=%b ig=%b arm=%b irq=%b exp gch=%b dg=%b cg=%b ig=%b arm=%b irq=%b",
                   e.tag, dma_grant_ch, dma_grant, cpu_grant, irq_grant, ch_armed, dma_irq,
                   e.gch, exp_dg, !exp_dg, exp_ig, e.armed, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    //   cl dl  req     launch  end     last    irqen   ip ack  gch     armed   irq
    step(0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0000, 0, "R1 reset state");
    step(0, 0, 4'b0000, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R5 launch arms ch0 ch2");
    step(0, 0, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0001, 4'b0101, 0, "R6 R4 lowest armed wins over irq");
    step(3, 0, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0001, 4'b0101, 0, "R7 hold despite level rise");
    step(3, 0, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0000, 4'b0101, 0, "R2 R8 raised cpu level blocks new grant");
    step(2, 0, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R3 dma level 0 blocked at cpu 2");
    step(1, 1, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0100, 4'b0101, 0, "R2 equal levels qualify, R5 unarmed ch1 ignored");
    step(1, 1, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R5 only unarmed requesters");
    step(3, 3, 4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b1101, 0, "R8 new arm not used same edge");
    step(3, 3, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b1000, 4'b1101, 0, "R3 level 3 runs at cpu 3");
    step(3, 3, 4'b1000, 4'b0000, 4'b1000, 4'b1000, 4'b1000, 0, 0, 4'b1000, 4'b0101, 1, "R9 R5 enabled last end sets irq and disarms");
    step(3, 3, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 0, 1, 4'b0000, 4'b0101, 1, "R10 set wins over ack");
    step(3, 3, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 1, 4'b0000, 4'b0101, 0, "R10 ack clears irq");
    step(3, 3, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R9 end without enable ignored");
    step(3, 3, 4'b0000, 4'b0100, 4'b0100, 4'b0100, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R5 launch beats disarm");
    step(3, 3, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 0, 0, 4'b0000, 4'b0100, 0, "R5 last end disarms ch0");
    step(2, 1, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0000, 4'b0100, 0, "R2 dma below cpu blocked");
    step(0, 0, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0100, 4'b0100, 0, "R3 level 0 runs at cpu 0");
    step(0, 0, 4'b0100, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0100, 4'b0101, 0, "R7 ch2 holds, ch0 relaunched");
    step(0, 0, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0100, 4'b0101, 0, "R7 lower channel waits");
    step(0, 0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0001, 4'b0101, 0, "R7 direct handoff to ch0");
    step(0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 0, 4'b0000, 4'b0101, 0, "R4 path returns to cpu");
    step(0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0101, 0, "R4 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule